// File: doc/BRIEF.md
# Compare-match event timer

This block is a free-running up-counter with a single compare register. Its purpose is to generate an operating-system tick or a one-shot event. Software reaches it over a small register bus. Through that bus it can:
- load the compare value,
- read the live count,
- start or stop counting,
- choose whether a match sends the count back to zero,
- zero the count by writing a strobe register.

A two-bit divider code slows the count to one step every 1 to 4 clocks. A lock bit protects the divider against stray writes.

The count and the match value are compared for equality. The interrupt output pulses for one clock when the count first equals the match value while the timer is running. A sticky pending pin holds the event until software writes the clear register.

The register bus is a plain control port with no handshake. A write is taken on any clock edge where the write enable is high. Read data follows the read address combinationally in the same cycle.

Top module: `evt_timer`

## Requirements
- R1: After reset the timer is stopped and the count reads 0. The match register reads all ones, masked to the counter width. The control, divider and lock registers read 0. Both the interrupt and pending outputs are low.
- R2: While the run bit (bit 0 of the control register, offset 0x08) is set, the count rises by one on each prescaler tick. While it is clear, the count holds. If the run bit is set by the write captured at edge W and cleared by the write captured at edge D, the count grows by floor((D-W)/(d+1)), where d is the divider code.
- R3: The divider code in bits [1:0] of offset 0x34 selects one tick per d+1 clocks. Codes 0, 1, 2 and 3 therefore divide by 1, 2, 3 and 4.
- R4: The count wraps from its all-ones value to 0, modulo 2^CNT_W.
- R5: The interrupt output is high for exactly one clock. That clock is the first one in which the count equals the match value while the run bit is set.
- R6: Matching is an equality test. A match value below the current count fires only after the counter wraps round to it.
- R7: With the auto-zero bit (bit 1 of offset 0x08) set, the tick after a match takes the count to 0. A match value M then gives one interrupt every M+1 ticks.
- R8: A match sets the pending output on the clock after the interrupt pulse. The pending output stays high until a write to offset 0x0C.
- R9: Any write to offset 0x0C zeros the count and the prescaler phase at its capture edge. After that edge, the tick pattern restarts as it would from a fresh start.
- R10: While bit 0 of the lock register (offset 0x20) is set, writes to the divider register are ignored. Writes to the lock register itself are always accepted.
- R11: The count register at offset 0x04 is read-only, and writes to it are ignored. Offset 0x00 reads back the match value. Offset 0x08 reads {auto-zero, run} in bits [1:0]. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write enable, one write per high cycle |
| bus_addr | input | 8 | Byte offset for read and write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| irq_pulse | output | 1 | One-clock match event |
| evt_pending | output | 1 | Sticky match flag, cleared by the clear strobe |

## Verification
The bench builds the timer with CNT_W set to 8 and DATA_W left at 32. With that setting, a wrap of the counter takes 256 ticks. Both the modulo wrap and the "match value behind the count" case therefore complete within a short run. The wide read path still zero-extends the narrow count. The divider is exercised at codes 2 and 3, including a restart of the prescaler phase partway through a tick period.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFF_MATCH = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_COUNT = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_CLEAR = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_LOCK  = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_DIV   = 8'h34;

  typedef struct packed {
    logic zero_on_hit;
    logic run;
  } tmr_ctrl_t;
endpackage

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import evt_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  match_val,
  output tmr_ctrl_t         ctrl,
  output logic [DIV_W-1:0]  div_code,
  output logic              clear_stb,
  output logic [DATA_W-1:0] rdata
);
  logic lock_q;

  assign clear_stb = we && (addr == OFF_CLEAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_val <= '1;
      ctrl      <= '0;
      div_code  <= '0;
      lock_q    <= 1'b0;
    end else if (we) begin
      case (addr)
        OFF_MATCH: match_val <= wdata[CNT_W-1:0];
        OFF_CTRL:  ctrl      <= tmr_ctrl_t'(wdata[1:0]);
        OFF_LOCK:  lock_q    <= wdata[0];
        OFF_DIV:   if (!lock_q) div_code <= wdata[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      OFF_MATCH: rdata = DATA_W'(match_val);
      OFF_COUNT: rdata = DATA_W'(count);
      OFF_CTRL:  rdata = DATA_W'(ctrl);
      OFF_LOCK:  rdata = DATA_W'(lock_q);
      OFF_DIV:   rdata = DATA_W'(div_code);
      default:   rdata = '0;
    endcase
  end

  generate
    if (DATA_W > CNT_W) begin : g_wide_bus
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^wdata[DATA_W-1:CNT_W];
    end
  endgenerate

  // R10: a divider write while locked leaves the divider untouched
  assert_lock_holds_div_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && we && addr == OFF_DIV) |=> $stable(div_code));
endmodule

// File: rtl/evt_timer_presc.sv
module evt_timer_presc #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_code,
  output logic             tick
);
  logic [DIV_W-1:0] phase;

  assign tick = run && !restart && (phase >= div_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         phase <= '0;
    else if (!run || restart)           phase <= '0;
    else if (phase >= div_code)         phase <= '0;
    else                                phase <= phase + DIV_W'(1);
  end

  // R2: ticks only while running
  assert_tick_needs_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run);
  // R3: with a divider above one, ticks are never back to back
  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_code != '0) |=> (!tick || div_code == '0));
endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             zero_on_hit,
  input  logic             restart,
  input  logic [CNT_W-1:0] match_val,
  output logic [CNT_W-1:0] count,
  output logic             irq,
  output logic             pending
);
  logic equal, hit, hit_q;

  assign equal = (count == match_val);
  assign hit   = run && equal;
  assign irq   = hit && !hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      hit_q   <= 1'b0;
      pending <= 1'b0;
    end else begin
      hit_q <= hit;
      if (restart)                         count <= '0;
      else if (tick && zero_on_hit && equal) count <= '0;
      else if (tick)                       count <= count + CNT_W'(1);
      if (irq)          pending <= 1'b1;
      else if (restart) pending <= 1'b0;
    end
  end

  // R5: the event pulse lasts a single clock
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R8: an event leaves the pending flag set
  assert_pending_after_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> pending);
  // R4: all-ones steps to zero on a plain tick
  assert_wrap_to_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && count == '1 && !(zero_on_hit && equal)) |=> count == '0);
  // R7: auto-zero after a match
  assert_zero_on_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && zero_on_hit && equal) |=> count == '0);
  // R9: a clear strobe empties the count
  assert_clear_zeroes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> count == '0);
  // R2: no tick and no clear leaves the count still
  assert_hold_without_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(count));
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [7:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_pulse,
  output logic              evt_pending
);
  logic [CNT_W-1:0] count, match_val;
  tmr_ctrl_t        ctrl;
  logic [DIV_W-1:0] div_code;
  logic             clear_stb, tick;

  evt_timer_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .count(count), .match_val(match_val), .ctrl(ctrl), .div_code(div_code),
    .clear_stb(clear_stb), .rdata(bus_rdata)
  );

  evt_timer_presc #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .restart(clear_stb),
    .div_code(div_code), .tick(tick)
  );

  evt_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(ctrl.run),
    .zero_on_hit(ctrl.zero_on_hit), .restart(clear_stb), .match_val(match_val),
    .count(count), .irq(irq_pulse), .pending(evt_pending)
  );
endmodule

// File: tb/evt_timer_tb_top.sv
module evt_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic irq_pulse, evt_pending;

  int checks = 0, failures = 0, cyc = 0, last_wr = 0;
  bit finished = 0;

  typedef struct { int v; string tag; } exp_t;
  exp_t rd_q[$];
  exp_t irq_q[$];
  event rd_ev;

  evt_timer #(.CNT_W(CW), .DATA_W(DW), .DIV_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pulse(irq_pulse), .evt_pending(evt_pending)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, int d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    last_wr = cyc;
    bus_we = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic rd(logic [7:0] a, int exp, string tag);
    exp_t e;
    @(negedge clk);
    bus_addr = a; #1;
    e.v = exp; e.tag = tag;
    rd_q.push_back(e);
    -> rd_ev;
    #1;
  endtask

  task automatic want_irq(int c, string tag);
    exp_t e;
    e.v = c; e.tag = tag;
    irq_q.push_back(e);
  endtask

  // read monitor
  initial begin
    forever begin
      exp_t e;
      @(rd_ev);
      e = rd_q.pop_front();
      check(e.tag, int'(bus_rdata), e.v);
    end
  end

  // event monitor
  always @(negedge clk) begin
    if (rst_n && irq_pulse) begin
      if (irq_q.size() == 0) check("R5 unexpected event pulse", cyc, -1);
      else begin
        exp_t e;
        e = irq_q.pop_front();
        check(e.tag, cyc, e.v);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      while (irq_q.size() > 0) begin
        exp_t e;
        e = irq_q.pop_front();
        check({e.tag, " missing event"}, -1, e.v);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    int w, d, c, x;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, 255, "R1 match reset");
    rd(8'h04, 0, "R1 count reset");
    rd(8'h08, 0, "R1 control reset");
    rd(8'h34, 0, "R1 divider reset");
    rd(8'h20, 0, "R1 lock reset");
    check("R1 irq low", int'(irq_pulse), 0);
    check("R1 pending low", int'(evt_pending), 0);
    rd(8'h10, 0, "R11 unmapped reads zero");

    // R2 counting at divide by 1, hold while stopped
    wr(8'h08, 1); w = last_wr;
    idle(9);
    wr(8'h08, 0); d = last_wr;
    rd(8'h04, (d - w) / 1, "R2 count after run");
    idle(5);
    rd(8'h04, (d - w) / 1, "R2 count holds when stopped");
    wr(8'h0C, 0);
    rd(8'h04, 0, "R9 clear zeroes count");

    // R3 divide by 3
    wr(8'h34, 2);
    rd(8'h34, 2, "R3 divider readback");
    wr(8'h08, 1); w = last_wr;
    idle(12);
    wr(8'h08, 0); d = last_wr;
    rd(8'h04, (d - w) / 3, "R3 count at divide by 3");

    // R10 lock
    wr(8'h20, 1);
    rd(8'h20, 1, "R10 lock set");
    wr(8'h34, 3);
    rd(8'h34, 2, "R10 divider write ignored when locked");
    wr(8'h20, 0);
    rd(8'h20, 0, "R10 lock register writable while locked");
    wr(8'h34, 3);
    rd(8'h34, 3, "R10 divider write accepted when unlocked");

    // R9 phase restart at divide by 4
    wr(8'h0C, 0);
    wr(8'h08, 1);
    idle(6);
    wr(8'h0C, 0); c = last_wr;
    idle(5);
    wr(8'h08, 0); d = last_wr;
    rd(8'h04, (d - c) / 4, "R9 count after phase restart");

    // R11 count is read-only
    wr(8'h04, 8'h55);
    rd(8'h04, (d - c) / 4, "R11 count write ignored");

    // R5 / R8 single event, no auto-zero
    wr(8'h34, 0);
    wr(8'h0C, 0);
    wr(8'h00, 5);
    rd(8'h00, 5, "R11 match readback");
    wr(8'h08, 1); w = last_wr;
    want_irq(w + 5, "R5 event cycle");
    idle(10);
    @(negedge clk);
    check("R8 pending set after event", int'(evt_pending), 1);
    wr(8'h08, 0); d = last_wr;
    rd(8'h04, d - w, "R6 count runs past match without auto-zero");
    @(negedge clk);
    check("R8 pending holds", int'(evt_pending), 1);
    wr(8'h0C, 0);
    @(negedge clk);
    check("R8 pending cleared by clear write", int'(evt_pending), 0);

    // R7 auto-zero, period M+1
    wr(8'h00, 3);
    wr(8'h08, 3); w = last_wr;
    for (int k = 0; k < 5; k++) want_irq(w + 3 + 4 * k, "R7 periodic event");
    idle(20);
    wr(8'h08, 0); d = last_wr;
    rd(8'h04, (d - w) % 4, "R7 count after auto-zero run");
    wr(8'h08, 2);
    rd(8'h08, 2, "R11 control readback");
    wr(8'h08, 0);

    // R4 / R6 wrap and match behind count
    wr(8'h0C, 0);
    wr(8'h00, 255);
    wr(8'h08, 1); w = last_wr;
    idle(19);
    wr(8'h00, 10); x = last_wr;
    check("R6 match written behind count", x - w, 20);
    want_irq(w + 256 + 10, "R6 event only after wrap");
    idle(279);
    wr(8'h08, 0); d = last_wr;
    rd(8'h04, (d - w) % 256, "R4 count wraps modulo 2^CNT_W");

    idle(3);
    finish_run();
  end
endmodule